// File: doc/BRIEF.md
# Configuration Access Engine

This block lets software issue one configuration read or one configuration write on a downstream link through a small set of memory-mapped registers, then find the result by polling. Software first programs a transaction type, a 64-bit target address, write data and a byte-lane strobe. It then writes 1 to the start register. The engine takes a snapshot of the programmed fields and presents them as a single request on a valid/ready handshake. After that it waits for one completion beat.

When the completion arrives, the engine stores the completion status code. For the two read types it also stores the returned data. It then clears the start register and sets the done bit of the interrupt status. Software detects that the access is finished when start reads 0 while the interrupt status reads nonzero. Software handles timeouts and retries. The register bus is a plain single-cycle write port with a read data output that decodes the register address combinationally.

Register word indices on `reg_addr`: 0 start, 1 interrupt status, 2 control, 3 status, 4 address low, 5 address high, 6 write data, 7 strobe, 8 read data. Any other index reads 0.

Top module: `cfgx_engine`

## Requirements
- R1: After reset every register reads 0 and `req_valid` is 0.
- R2: Control keeps its type field in bits [3:0] and its window-bypass flag in bit 24, and every other control bit reads 0. Address low and high and write data read back exactly as written. The strobe register keeps bits [3:0]. Writes to status (index 3) and read data (index 8) change nothing.
- R3: Writing a word with bit 0 set to start while the engine is idle raises `req_valid` on the next cycle, and start then reads 1. `req_valid` is held until a cycle in which `req_ready` is high. The request carries the type, the bypass flag, the address {high, low} with bits [1:0] forced to 0, the strobe, and the write data with the bytes of disabled lanes driven to 0.
- R4: The request fields are captured at launch. Register writes made after launch do not change them.
- R5: A write to start while a request is outstanding is ignored, so no second request follows the completion.
- R6: The first `cpl_valid` after the handshake ends the access. On the next cycle start reads 0, interrupt status bit 0 reads 1, and status bits [9:7] hold `cpl_status`: 0 success, 1 unsupported request, 2 configuration retry, 4 completer abort.
- R7: At launch, status bit 0 becomes 1 when the type is one of the configuration codes 0x8 (read Type0), 0x9 (read Type1), 0xA (write Type0) or 0xB (write Type1), and 0 for any other code.
- R8: Only types 0x8 and 0x9 load `cpl_data` into the read-data register. For every other type the read-data register keeps its last value.
- R9: Interrupt status bit 0 is cleared by writing 1 to it. Writing 0 has no effect. When a clear and a completion fall in the same cycle, the bit stays set.
- R10: A `cpl_valid` received while the engine is idle, or while it is still waiting for `req_ready`, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index, used for both writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the register at `reg_addr` |
| req_valid | output | 1 | Downstream request valid |
| req_ready | input | 1 | Downstream request accepted |
| req_type | output | 4 | Transaction type code |
| req_win_bypass | output | 1 | Skip outbound address window translation |
| req_addr | output | 64 | Dword-aligned target address |
| req_wdata | output | 32 | Write data with disabled lanes zeroed |
| req_strb | output | 4 | Byte-lane strobe |
| cpl_valid | input | 1 | Completion beat |
| cpl_status | input | 3 | Completion status code |
| cpl_data | input | 32 | Completion read data |

## Verification
A stuck sequencer state is visible on the very next register read: start either stays at 1 after a completion, or a request is launched a second time. The second launch shows up as a new `req_valid` in the cycles after done. A capture path with the wrong enable changes the read-data register after a write-type or idle completion. That error appears in the first readback after the beat. Because the request fields are captured at launch, any leak from live registers appears on `req_addr` within one cycle of the offending register write.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int KIND_W          = 4;
    localparam int CODE_W          = 3;
    localparam int CTRL_BYPASS_BIT = 24;
    localparam int STAT_CODE_LSB   = 7;
    localparam int STAT_NP_BIT     = 0;

    localparam logic [KIND_W-1:0] KIND_CFG_RD0 = 4'h8;
    localparam logic [KIND_W-1:0] KIND_CFG_RD1 = 4'h9;
    localparam logic [KIND_W-1:0] KIND_CFG_WR0 = 4'hA;
    localparam logic [KIND_W-1:0] KIND_CFG_WR1 = 4'hB;

    localparam int IDX_START   = 0;
    localparam int IDX_IRQ     = 1;
    localparam int IDX_CTRL    = 2;
    localparam int IDX_STAT    = 3;
    localparam int IDX_ADDR_LO = 4;
    localparam int IDX_ADDR_HI = 5;
    localparam int IDX_WDATA   = 6;
    localparam int IDX_STRB    = 7;
    localparam int IDX_RDATA   = 8;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic              bypass;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_AWAIT = 2'd2
    } seq_e;

    function automatic logic kind_is_cfg(input logic [KIND_W-1:0] k);
        return (k == KIND_CFG_RD0) || (k == KIND_CFG_RD1) ||
               (k == KIND_CFG_WR0) || (k == KIND_CFG_WR1);
    endfunction

    function automatic logic kind_is_read(input logic [KIND_W-1:0] k);
        return (k == KIND_CFG_RD0) || (k == KIND_CFG_RD1);
    endfunction

endpackage

// File: rtl/cfgx_regfile.sv
module cfgx_regfile
    import cfgx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HI_W   = 32,
    parameter int AW     = 4,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] addr_lo_q,
    output logic [HI_W-1:0]   addr_hi_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [STRB_W-1:0] strb_q,
    output logic              start_pulse,
    output logic              isr_clear
);

    logic hit_ctrl, hit_lo, hit_hi, hit_wd, hit_strb;

    assign hit_ctrl = wr_en && (wr_addr == AW'(IDX_CTRL));
    assign hit_lo   = wr_en && (wr_addr == AW'(IDX_ADDR_LO));
    assign hit_hi   = wr_en && (wr_addr == AW'(IDX_ADDR_HI));
    assign hit_wd   = wr_en && (wr_addr == AW'(IDX_WDATA));
    assign hit_strb = wr_en && (wr_addr == AW'(IDX_STRB));

    assign start_pulse = wr_en && (wr_addr == AW'(IDX_START)) && wr_data[0];
    assign isr_clear   = wr_en && (wr_addr == AW'(IDX_IRQ)) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            wdata_q   <= '0;
            strb_q    <= '0;
        end else begin
            if (hit_ctrl) begin
                ctrl_q.kind   <= wr_data[KIND_W-1:0];
                ctrl_q.bypass <= wr_data[CTRL_BYPASS_BIT];
            end
            if (hit_lo)   addr_lo_q <= wr_data;
            if (hit_hi)   addr_hi_q <= wr_data[HI_W-1:0];
            if (hit_wd)   wdata_q   <= wr_data;
            if (hit_strb) strb_q    <= wr_data[STRB_W-1:0];
        end
    end

endmodule

// File: rtl/cfgx_sequencer.sv
module cfgx_sequencer
    import cfgx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HI_W   = 32,
    localparam int STRB_W = DATA_W / 8,
    localparam int FULL_W = DATA_W + HI_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_pulse,
    input  ctrl_t             ctrl_i,
    input  logic [DATA_W-1:0] addr_lo_i,
    input  logic [HI_W-1:0]   addr_hi_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [STRB_W-1:0] strb_i,
    input  logic              req_ready,
    input  logic              cpl_valid,
    output logic              busy,
    output logic              waiting,
    output logic              launch,
    output logic              cpl_take,
    output logic              req_valid,
    output ctrl_t             req_ctrl,
    output logic [FULL_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    output logic [STRB_W-1:0] req_strb
);

    seq_e              state_q;
    logic [DATA_W-1:0] lane_data;
    logic [FULL_W-1:0] aligned_addr;

    for (genvar g = 0; g < STRB_W; g++) begin : g_lane
        assign lane_data[g*8 +: 8] = strb_i[g] ? wdata_i[g*8 +: 8] : 8'h00;
    end

    assign aligned_addr = {addr_hi_i, addr_lo_i[DATA_W-1:2], 2'b00};

    assign busy      = (state_q != SEQ_IDLE);
    assign req_valid = (state_q == SEQ_ISSUE);
    assign waiting   = (state_q == SEQ_AWAIT);
    assign launch    = (state_q == SEQ_IDLE) && start_pulse;
    assign cpl_take  = waiting && cpl_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SEQ_IDLE;
            req_ctrl  <= '0;
            req_addr  <= '0;
            req_wdata <= '0;
            req_strb  <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start_pulse) begin
                        state_q   <= SEQ_ISSUE;
                        req_ctrl  <= ctrl_i;
                        req_addr  <= aligned_addr;
                        req_wdata <= lane_data;
                        req_strb  <= strb_i;
                    end
                end
                SEQ_ISSUE: if (req_ready) state_q <= SEQ_AWAIT;
                SEQ_AWAIT: if (cpl_valid) state_q <= SEQ_IDLE;
                default:   state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfgx_capture.sv
module cfgx_capture
    import cfgx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [KIND_W-1:0] launch_kind,
    input  logic              cpl_take,
    input  logic [KIND_W-1:0] held_kind,
    input  logic [CODE_W-1:0] cpl_status,
    input  logic [DATA_W-1:0] cpl_data,
    input  logic              isr_clear,
    output logic              nonposted_q,
    output logic [CODE_W-1:0] code_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              isr_done_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            nonposted_q <= 1'b0;
            code_q      <= '0;
            rdata_q     <= '0;
            isr_done_q  <= 1'b0;
        end else begin
            if (launch) nonposted_q <= kind_is_cfg(launch_kind);
            if (cpl_take) begin
                code_q <= cpl_status;
                if (kind_is_read(held_kind)) rdata_q <= cpl_data;
            end
            if (cpl_take)       isr_done_q <= 1'b1;
            else if (isr_clear) isr_done_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cfgx_engine.sv
module cfgx_engine
    import cfgx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HI_W   = 32,
    parameter int AW     = 4,
    localparam int STRB_W = DATA_W / 8,
    localparam int FULL_W = DATA_W + HI_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [KIND_W-1:0] req_type,
    output logic              req_win_bypass,
    output logic [FULL_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    output logic [STRB_W-1:0] req_strb,
    input  logic              cpl_valid,
    input  logic [CODE_W-1:0] cpl_status,
    input  logic [DATA_W-1:0] cpl_data
);

    ctrl_t             ctrl_q;
    ctrl_t             req_ctrl;
    logic [DATA_W-1:0] addr_lo_q, wdata_q, rd_data_q;
    logic [HI_W-1:0]   addr_hi_q;
    logic [STRB_W-1:0] strb_q;
    logic              start_pulse, isr_clear;
    logic              busy, waiting, launch, cpl_take;
    logic              nonposted_q, isr_done;
    logic [CODE_W-1:0] code_q;

    cfgx_regfile #(.DATA_W(DATA_W), .HI_W(HI_W), .AW(AW)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr_en), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .ctrl_q(ctrl_q), .addr_lo_q(addr_lo_q), .addr_hi_q(addr_hi_q),
        .wdata_q(wdata_q), .strb_q(strb_q),
        .start_pulse(start_pulse), .isr_clear(isr_clear)
    );

    cfgx_sequencer #(.DATA_W(DATA_W), .HI_W(HI_W)) u_seq (
        .clk(clk), .rst(rst),
        .start_pulse(start_pulse), .ctrl_i(ctrl_q),
        .addr_lo_i(addr_lo_q), .addr_hi_i(addr_hi_q),
        .wdata_i(wdata_q), .strb_i(strb_q),
        .req_ready(req_ready), .cpl_valid(cpl_valid),
        .busy(busy), .waiting(waiting), .launch(launch), .cpl_take(cpl_take),
        .req_valid(req_valid), .req_ctrl(req_ctrl), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_strb(req_strb)
    );

    cfgx_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst(rst),
        .launch(launch), .launch_kind(ctrl_q.kind),
        .cpl_take(cpl_take), .held_kind(req_ctrl.kind),
        .cpl_status(cpl_status), .cpl_data(cpl_data),
        .isr_clear(isr_clear),
        .nonposted_q(nonposted_q), .code_q(code_q),
        .rdata_q(rd_data_q), .isr_done_q(isr_done)
    );

    assign req_type       = req_ctrl.kind;
    assign req_win_bypass = req_ctrl.bypass;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(IDX_START)) begin
            reg_rdata[0] = busy;
        end else if (reg_addr == AW'(IDX_IRQ)) begin
            reg_rdata[0] = isr_done;
        end else if (reg_addr == AW'(IDX_CTRL)) begin
            reg_rdata[KIND_W-1:0]     = ctrl_q.kind;
            reg_rdata[CTRL_BYPASS_BIT] = ctrl_q.bypass;
        end else if (reg_addr == AW'(IDX_STAT)) begin
            reg_rdata[STAT_NP_BIT]                      = nonposted_q;
            reg_rdata[STAT_CODE_LSB +: CODE_W]          = code_q;
        end else if (reg_addr == AW'(IDX_ADDR_LO)) begin
            reg_rdata = addr_lo_q;
        end else if (reg_addr == AW'(IDX_ADDR_HI)) begin
            reg_rdata[HI_W-1:0] = addr_hi_q;
        end else if (reg_addr == AW'(IDX_WDATA)) begin
            reg_rdata = wdata_q;
        end else if (reg_addr == AW'(IDX_STRB)) begin
            reg_rdata[STRB_W-1:0] = strb_q;
        end else if (reg_addr == AW'(IDX_RDATA)) begin
            reg_rdata = rd_data_q;
        end
    end

endmodule

// File: rtl/cfgx_engine_chk.sv
module cfgx_engine_chk #(
    parameter int DATA_W = 32,
    parameter int FULL_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [FULL_W-1:0] req_addr,
    input logic              busy,
    input logic              waiting,
    input logic              cpl_valid,
    input logic              isr_done,
    input logic [DATA_W-1:0] rd_data_q
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr))); // R3

    AST_LAUNCH_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> !$past(busy)); // R5

    AST_DONE_AFTER_CPL: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && waiting) |=> (isr_done && !busy)); // R6

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(cpl_valid && waiting) |=> $stable(rd_data_q)); // R8

    AST_DONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(isr_done) |-> $past(cpl_valid && waiting)); // R10

endmodule

bind cfgx_engine cfgx_engine_chk #(.DATA_W(DATA_W), .FULL_W(FULL_W)) u_chk (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .busy(busy), .waiting(waiting), .cpl_valid(cpl_valid),
    .isr_done(isr_done), .rd_data_q(rd_data_q)
);

// File: tb/tb_cfgx_engine.sv
module tb_cfgx_engine;

    localparam logic [3:0] A_START = 4'd0, A_IRQ = 4'd1, A_CTRL = 4'd2, A_STAT = 4'd3,
                           A_LO = 4'd4, A_HI = 4'd5, A_WD = 4'd6, A_STRB = 4'd7, A_RD = 4'd8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [3:0]  req_type;
    logic        req_win_bypass;
    logic [63:0] req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  req_strb;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_status = '0;
    logic [31:0] cpl_data = '0;

    int checks = 0;
    int errors = 0;
    logic        finished = 1'b0;
    logic [31:0] exp_rdata = '0;

    always #5 clk = ~clk;

    cfgx_engine dut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
        .req_win_bypass(req_win_bypass), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_strb(req_strb), .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data)
    );

    function automatic logic [31:0] lane_mask(input logic [31:0] d, input logic [3:0] s);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[b*8 +: 8] = s[b] ? d[b*8 +: 8] : 8'h00;
        return r;
    endfunction

    function automatic logic is_cfg(input logic [3:0] t);
        return (t >= 4'h8) && (t <= 4'hB);
    endfunction

    function automatic logic is_rd(input logic [3:0] t);
        return (t == 4'h8) || (t == 4'h9);
    endfunction

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic run_access(input logic [3:0] t, input logic bp, input logic [31:0] lo,
                              input logic [31:0] hi, input logic [31:0] wd, input logic [3:0] sb,
                              input int rdy_wait, input int cpl_wait,
                              input logic [2:0] code, input logic [31:0] cd);
        logic [31:0] v;
        wr(A_CTRL, (32'(bp) << 24) | 32'(t));
        wr(A_LO, lo); wr(A_HI, hi); wr(A_WD, wd); wr(A_STRB, 32'(sb));
        wr(A_START, 32'd0); wr(A_IRQ, 32'd1);
        wr(A_START, 32'd1);
        check("R3 req_valid", 64'(req_valid), 64'd1);
        check("R3 req_type", 64'(req_type), 64'(t));
        check("R3 bypass", 64'(req_win_bypass), 64'(bp));
        check("R3 req_addr", req_addr, {hi, lo[31:2], 2'b00});
        check("R3 req_wdata", 64'(req_wdata), 64'(lane_mask(wd, sb)));
        check("R3 req_strb", 64'(req_strb), 64'(sb));
        rd(A_START, v); check("R3 start busy", 64'(v), 64'd1);
        rd(A_STAT, v);  check("R7 nonposted", 64'(v[0]), 64'(is_cfg(t)));
        for (int k = 0; k < rdy_wait; k++) begin
            @(negedge clk);
            check("R3 held", 64'(req_valid), 64'd1);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        check("R3 dropped", 64'(req_valid), 64'd0);
        for (int k = 0; k < cpl_wait; k++) begin
            @(negedge clk);
            rd(A_IRQ, v); check("R6 not done", 64'(v), 64'd0);
        end
        cpl_valid = 1'b1; cpl_status = code; cpl_data = cd;
        @(negedge clk);
        cpl_valid = 1'b0;
        if (is_rd(t)) exp_rdata = cd;
        rd(A_START, v); check("R6 start clear", 64'(v), 64'd0);
        rd(A_IRQ, v);   check("R6 done", 64'(v), 64'd1);
        rd(A_STAT, v);  check("R6 code", 64'(v[9:7]), 64'(code));
        rd(A_RD, v);    check("R8 rdata", 64'(v), 64'(exp_rdata));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [2:0] codes [4];
        codes[0] = 3'd0; codes[1] = 3'd1; codes[2] = 3'd2; codes[3] = 3'd4;
        v = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), v); check("R1 reset reg", 64'(v), 64'd0);
        end
        check("R1 req_valid", 64'(req_valid), 64'd0);

        // R2 readback
        wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); check("R2 ctrl", 64'(v), 64'h0100_000F);
        wr(A_LO, 32'hDEAD_BEEF);   rd(A_LO, v);   check("R2 lo", 64'(v), 64'hDEAD_BEEF);
        wr(A_HI, 32'h1234_5678);   rd(A_HI, v);   check("R2 hi", 64'(v), 64'h1234_5678);
        wr(A_WD, 32'hCAFE_F00D);   rd(A_WD, v);   check("R2 wdata", 64'(v), 64'hCAFE_F00D);
        wr(A_STRB, 32'hFF);        rd(A_STRB, v); check("R2 strb", 64'(v), 64'hF);
        wr(A_STAT, 32'hFFFF_FFFF); rd(A_STAT, v); check("R2 status ro", 64'(v), 64'd0);
        wr(A_RD, 32'hFFFF_FFFF);   rd(A_RD, v);   check("R2 rdata ro", 64'(v), 64'd0);

        // R10 completion while idle
        @(negedge clk);
        cpl_valid = 1'b1; cpl_status = 3'd4; cpl_data = 32'h5555_AAAA;
        @(negedge clk);
        cpl_valid = 1'b0;
        rd(A_IRQ, v);  check("R10 idle isr", 64'(v), 64'd0);
        rd(A_STAT, v); check("R10 idle status", 64'(v), 64'd0);
        rd(A_RD, v);   check("R10 idle rdata", 64'(v), 64'd0);

        // directed accesses over types and codes
        run_access(4'h8, 1'b1, 32'h0010_0007, 32'h0, 32'h0, 4'hF, 0, 0, 3'd0, 32'h1111_2222);
        run_access(4'hB, 1'b0, 32'h0123_8004, 32'h0, 32'hAABB_CCDD, 4'h6, 2, 1, 3'd4, 32'h9999_9999);
        run_access(4'h9, 1'b0, 32'h0FF0_0FFC, 32'h1, 32'h0, 4'h3, 1, 3, 3'd2, 32'h3333_4444);
        run_access(4'hA, 1'b1, 32'h0000_2008, 32'h0, 32'h0000_00EE, 4'h8, 0, 2, 3'd1, 32'h7777_7777);
        run_access(4'h3, 1'b0, 32'h0000_0010, 32'h0, 32'h1, 4'h1, 0, 0, 3'd0, 32'h8888_8888);

        // R4 / R5 / R10: edits and start while busy; completion during issue ignored
        wr(A_CTRL, 32'h9); wr(A_LO, 32'h0000_1000); wr(A_HI, 32'h0); wr(A_IRQ, 32'd1);
        wr(A_START, 32'd1);
        wr(A_LO, 32'h0000_2000);
        wr(A_CTRL, 32'hA);
        wr(A_START, 32'd1);
        check("R4 addr frozen", req_addr, 64'h0000_1000);
        check("R4 type frozen", 64'(req_type), 64'h9);
        cpl_valid = 1'b1; cpl_data = 32'h6666_0000;
        @(negedge clk);
        cpl_valid = 1'b0;
        rd(A_IRQ, v); check("R10 cpl during issue", 64'(v), 64'd0);
        check("R10 still issuing", 64'(req_valid), 64'd1);
        req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
        cpl_valid = 1'b1; cpl_status = 3'd0; cpl_data = 32'hABCD_0123;
        @(negedge clk);
        cpl_valid = 1'b0;
        exp_rdata = 32'hABCD_0123;
        rd(A_RD, v); check("R4 read type kept", 64'(v), 64'(exp_rdata));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R5 no second request", 64'(req_valid), 64'd0);
        end

        // R9 W1C behaviour
        wr(A_IRQ, 32'd0); rd(A_IRQ, v); check("R9 write0 keeps", 64'(v), 64'd1);
        wr(A_IRQ, 32'd1); rd(A_IRQ, v); check("R9 write1 clears", 64'(v), 64'd0);
        wr(A_CTRL, 32'hA); wr(A_START, 32'd1);
        req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
        reg_wr_en = 1'b1; reg_addr = A_IRQ; reg_wdata = 32'd1;
        cpl_valid = 1'b1; cpl_status = 3'd1;
        @(negedge clk);
        reg_wr_en = 1'b0; cpl_valid = 1'b0;
        rd(A_IRQ, v); check("R9 set wins", 64'(v), 64'd1);

        // random accesses
        for (int i = 0; i < 24; i++) begin
            logic [3:0] t;
            int pick;
            pick = int'($urandom % 6);
            t = (pick < 4) ? 4'(8 + pick) : 4'($urandom % 8);
            run_access(t, 1'($urandom), $urandom, $urandom, $urandom, 4'($urandom),
                       int'($urandom % 3), int'($urandom % 3),
                       codes[$urandom % 4], $urandom);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule